// File: doc/BRIEF.md
# Graphics Command Packet Parser

The parser takes a stream of 32-bit command words on a valid/ready input. It finds where each packet ends by decoding the opcode in the top byte (bits 31:24) of the first word, or header. It then passes each whole packet, in order, to a rendering-queue output. The first word of each packet carries a start mark. A packet is not forwarded until all of its words have arrived. While a packet is incomplete, its words are held inside the block, and input gaps of any length are allowed.

As words arrive, the parser keeps eight 32-bit environment registers. Two things write them: settings headers store their whole word into one register, and textured primitives carry texture-page bits in a word inside the packet. A 13-bit status field is built from two of these registers.

Image-transfer commands are taken out of the stream and are not forwarded. Their position word and size word are passed to a separate transfer engine as a one-cycle request. A write transfer stops the parser from taking input until the engine reports that it is finished. The parser also gives a one-cycle mark for each packet that changes video memory.

Top module: `cmdpkt_parser`

## Requirements
- R1: The number of words after the header is set by the opcode, and the packet is 1 + that count words long. Counts by opcode:
  - 0x02: 2
  - 0x20–0x23: 3; 0x28–0x2B: 4; 0x30–0x33: 5; 0x24–0x27: 6; 0x38–0x3B: 7; 0x2C–0x2F: 8; 0x34–0x37: 8; 0x3C–0x3F: 11
  - 0x40–0x47: 2; 0x48–0x57: 3; 0x58–0x5F: 4
  - 0x60–0x63: 2; 0x64–0x67: 3; 0x68–0x6B: 1; 0x6C–0x6F: 0
  - 0x70–0x73: 1; 0x74–0x77: 2; 0x78–0x7B: 1; 0x7C–0x7F: 2
  - 0x80: 3; 0xA0: 2; 0xC0: 2
  - every other opcode: 0
- R2: Every packet other than 0xA0 and 0xC0 comes out on `out_data` whole and in arrival order. `out_sop` is 1 only on its first word. No word of a packet comes out before the last word of that packet has been accepted.
- R3: While a packet is being forwarded, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_sop` hold their values.
- R4: Texture-page bits are captured when a given packet word is accepted. If (opcode & 0xF4) == 0x24, word 4 (the header is word 0) writes its bits 8:0 into bits 8:0 of environment register 1. If (opcode & 0xF4) == 0x34, word 5 does the same. The capture is visible on the next cycle.
- R5: A header with (opcode & 0xF8) == 0xE0 is stored whole into environment register (opcode & 7). This header is still forwarded as a one-word packet. `env_out` bits 32k+31:32k show register k. All registers reset to 0.
- R6: `status_low` bits 10:0 equal environment register 1 bits 10:0. `status_low` bits 12:11 equal environment register 6 bits 1:0.
- R7: Opcodes 0xA0 and 0xC0 are not forwarded. On the cycle after their third word is accepted, `xfer_valid` is 1 for one cycle. `xfer_dir` is 0 for 0xA0 (write) and 1 for 0xC0 (read). `xfer_pos` is word 1 and `xfer_size` is word 2.
- R8: After a 0xA0 request, `in_ready` stays 0 until a cycle with `xfer_done` = 1. A 0xC0 request does not stop the input.
- R9: `dirty` is 1 for one cycle, on the cycle after the last word of any packet whose opcode is in 0x02–0xBF is accepted. It is 0 at all other times.
- R10: After reset, `in_ready` is 1, `out_valid`, `xfer_valid` and `dirty` are 0, and all environment and status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Parser accepts the offered word |
| out_valid | output | 1 | Rendering-queue word valid |
| out_data | output | 32 | Forwarded packet word |
| out_sop | output | 1 | First word of a forwarded packet |
| out_ready | input | 1 | Rendering queue takes the word |
| xfer_valid | output | 1 | One-cycle image-transfer request |
| xfer_dir | output | 1 | 0 write into memory, 1 read out |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_done | input | 1 | Write transfer finished |
| dirty | output | 1 | Packet that touches video memory completed |
| status_low | output | 13 | Status bits derived from environment |
| env_out | output | 256 | All eight environment registers, register k at bits 32k+31:32k |

## Verification
A 0xA0 write-transfer packet sets off two things in the same cycle. Its opcode lies in the memory-changing range, so it raises `dirty`. It is also an image-transfer command, so it raises `xfer_valid`. The bench sends 0xA0 packets with gaps between words and also back to back. It checks that both pulses appear on the same sample, one cycle after the size word is accepted, and that no word reaches the rendering queue. A 0xC0 read raises the transfer request without the dirty mark. That shows the two decisions are made separately.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

    localparam int WORD_W   = 32;
    localparam int ENV_NUM  = 8;
    localparam int ENV_TEX  = 1;
    localparam int ENV_MASK = 6;
    localparam int TEX_BITS = 9;
    localparam int STAT_W   = 13;

    typedef enum logic [1:0] {
        ST_GATHER = 2'd0,
        ST_SEND   = 2'd1,
        ST_XWAIT  = 2'd2
    } cpp_state_e;

    typedef struct packed {
        logic              valid;
        logic              dir;
        logic [WORD_W-1:0] pos;
        logic [WORD_W-1:0] size;
    } xfer_req_t;

    localparam logic [7:0] OP_IMG_WR = 8'hA0;
    localparam logic [7:0] OP_IMG_RD = 8'hC0;

    // Parameter words that follow a header carrying this opcode.
    function automatic logic [3:0] param_words(input logic [7:0] op);
        logic [3:0] n;
        n = 4'd0;
        case (op[7:5])
            3'b000: n = (op == 8'h02) ? 4'd2 : 4'd0;
            3'b001: begin
                case (op[4:2])
                    3'd0: n = 4'd3;
                    3'd1: n = 4'd6;
                    3'd2: n = 4'd4;
                    3'd3: n = 4'd8;
                    3'd4: n = 4'd5;
                    3'd5: n = 4'd8;
                    3'd6: n = 4'd7;
                    default: n = 4'd11;
                endcase
            end
            3'b010: begin
                case (op[4:3])
                    2'd0: n = 4'd2;
                    2'd3: n = 4'd4;
                    default: n = 4'd3;
                endcase
            end
            3'b011: begin
                case (op[4:2])
                    3'd0: n = 4'd2;
                    3'd1: n = 4'd3;
                    3'd2: n = 4'd1;
                    3'd3: n = 4'd0;
                    3'd4: n = 4'd1;
                    3'd5: n = 4'd2;
                    3'd6: n = 4'd1;
                    default: n = 4'd2;
                endcase
            end
            3'b100: n = (op == 8'h80) ? 4'd3 : 4'd0;
            3'b101: n = (op == OP_IMG_WR) ? 4'd2 : 4'd0;
            3'b110: n = (op == OP_IMG_RD) ? 4'd2 : 4'd0;
            default: n = 4'd0;
        endcase
        return n;
    endfunction

    // Index of the word carrying texture-page bits, 0 when none.
    function automatic logic [3:0] tex_word(input logic [7:0] op);
        if ((op & 8'hF4) == 8'h24) return 4'd4;
        if ((op & 8'hF4) == 8'h34) return 4'd5;
        return 4'd0;
    endfunction

    function automatic logic touches_vram(input logic [7:0] op);
        return (op >= 8'h02) && (op <= 8'hBF);
    endfunction

    function automatic logic is_env_op(input logic [7:0] op);
        return op[7:3] == 5'b11100;
    endfunction

endpackage

// File: rtl/cpp_pkt_store.sv
module cpp_pkt_store #(
    parameter int DEPTH  = 12,
    parameter int WIDTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_data;
    end

    assign rd_data = slots[rd_idx];

endmodule

// File: rtl/cpp_env_file.sv
module cpp_env_file
    import cpp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hdr_we,
    input  logic [2:0]                hdr_sel,
    input  logic [WORD_W-1:0]         hdr_data,
    input  logic                      tex_we,
    input  logic [TEX_BITS-1:0]       tex_bits,
    output logic [ENV_NUM*WORD_W-1:0] env_flat,
    output logic [STAT_W-1:0]         status_low
);

    logic [WORD_W-1:0] regs [ENV_NUM];

    for (genvar k = 0; k < ENV_NUM; k++) begin : g_reg
        if (k == ENV_TEX) begin : g_tex
            always_ff @(posedge clk) begin
                if (rst)
                    regs[k] <= '0;
                else if (hdr_we && hdr_sel == 3'(k))
                    regs[k] <= hdr_data;
                else if (tex_we)
                    regs[k][TEX_BITS-1:0] <= tex_bits;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    regs[k] <= '0;
                else if (hdr_we && hdr_sel == 3'(k))
                    regs[k] <= hdr_data;
            end
        end
        assign env_flat[k*WORD_W +: WORD_W] = regs[k];
    end

    assign status_low = {regs[ENV_MASK][1:0], regs[ENV_TEX][10:0]};

endmodule

// File: rtl/cmdpkt_parser.sv
module cmdpkt_parser
    import cpp_pkg::*;
#(
    parameter int DEPTH  = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [WORD_W-1:0]         in_data,
    output logic                      in_ready,
    output logic                      out_valid,
    output logic [WORD_W-1:0]         out_data,
    output logic                      out_sop,
    input  logic                      out_ready,
    output logic                      xfer_valid,
    output logic                      xfer_dir,
    output logic [WORD_W-1:0]         xfer_pos,
    output logic [WORD_W-1:0]         xfer_size,
    input  logic                      xfer_done,
    output logic                      dirty,
    output logic [STAT_W-1:0]         status_low,
    output logic [ENV_NUM*WORD_W-1:0] env_out
);

    cpp_state_e       state;
    logic [IDX_W-1:0] wr_idx, rd_idx, send_last, last_idx;
    logic [7:0]       cur_op;
    logic [WORD_W-1:0] pos_q;
    xfer_req_t        xreq;
    logic             dirty_q;

    logic             accept, is_hdr, done_now, is_img;
    logic [7:0]       op_now;
    logic [IDX_W-1:0] last_now;
    logic [3:0]       tex_at;
    logic             tex_we, hdr_we;

    assign in_ready = (state == ST_GATHER);
    assign accept   = in_valid && in_ready;
    assign is_hdr   = (wr_idx == '0);
    assign op_now   = is_hdr ? in_data[31:24] : cur_op;
    assign last_now = is_hdr ? IDX_W'(param_words(in_data[31:24])) : last_idx;
    assign done_now = accept && (wr_idx == last_now);
    assign is_img   = (op_now == OP_IMG_WR) || (op_now == OP_IMG_RD);
    assign tex_at   = tex_word(cur_op);
    assign tex_we   = accept && !is_hdr && (tex_at != 4'd0) && (wr_idx == IDX_W'(tex_at));
    assign hdr_we   = accept && is_hdr && is_env_op(in_data[31:24]);

    cpp_pkt_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (wr_idx),
        .wr_data (in_data),
        .rd_idx  (rd_idx),
        .rd_data (out_data)
    );

    cpp_env_file u_env (
        .clk        (clk),
        .rst        (rst),
        .hdr_we     (hdr_we),
        .hdr_sel    (in_data[26:24]),
        .hdr_data   (in_data),
        .tex_we     (tex_we),
        .tex_bits   (in_data[TEX_BITS-1:0]),
        .env_flat   (env_out),
        .status_low (status_low)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_GATHER;
            wr_idx    <= '0;
            rd_idx    <= '0;
            send_last <= '0;
            last_idx  <= '0;
            cur_op    <= '0;
            pos_q     <= '0;
            xreq      <= '0;
            dirty_q   <= 1'b0;
        end else begin
            xreq.valid <= done_now && is_img;
            dirty_q    <= done_now && touches_vram(op_now);
            if (done_now && is_img) begin
                xreq.dir  <= (op_now == OP_IMG_RD);
                xreq.pos  <= pos_q;
                xreq.size <= in_data;
            end
            case (state)
                ST_GATHER: begin
                    if (accept) begin
                        if (is_hdr) begin
                            cur_op   <= in_data[31:24];
                            last_idx <= last_now;
                        end
                        if (wr_idx == IDX_W'(1)) pos_q <= in_data;
                        if (done_now) begin
                            wr_idx <= '0;
                            if (op_now == OP_IMG_WR) begin
                                state <= ST_XWAIT;
                            end else if (op_now != OP_IMG_RD) begin
                                state     <= ST_SEND;
                                rd_idx    <= '0;
                                send_last <= last_now;
                            end
                        end else begin
                            wr_idx <= wr_idx + 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (out_ready) begin
                        if (rd_idx == send_last) state <= ST_GATHER;
                        else rd_idx <= rd_idx + 1'b1;
                    end
                end
                ST_XWAIT: begin
                    if (xfer_done) state <= ST_GATHER;
                end
                default: state <= ST_GATHER;
            endcase
        end
    end

    assign out_valid  = (state == ST_SEND);
    assign out_sop    = out_valid && (rd_idx == '0);
    assign xfer_valid = xreq.valid;
    assign xfer_dir   = xreq.dir;
    assign xfer_pos   = xreq.pos;
    assign xfer_size  = xreq.size;
    assign dirty      = dirty_q;

endmodule

// File: rtl/cpp_parser_chk.sv
module cpp_parser_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_sop,
    input logic        xfer_valid,
    input logic        xfer_dir,
    input logic        dirty
);

    // R3: no input taken while a packet is being forwarded
    a_r3_no_accept_in_send: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R3: forwarded word holds under backpressure
    a_r3_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)));

    // R7: transfer request is a single-cycle pulse and never forwarded
    a_r7_xfer_pulse: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |=> !xfer_valid);

    a_r7_no_fwd_xfer: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> !out_valid);

    // R8: write request holds the input closed
    a_r8_write_stall: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_dir) |-> !in_ready);

    // R9: dirty mark lasts one cycle
    a_r9_dirty_pulse: assert property (@(posedge clk) disable iff (rst)
        dirty |=> !dirty);

endmodule

bind cmdpkt_parser cpp_parser_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_sop    (out_sop),
    .xfer_valid (xfer_valid),
    .xfer_dir   (xfer_dir),
    .dirty      (dirty)
);

// File: tb/tb_cmdpkt_parser.sv
`timescale 1ns/1ps
module tb_cmdpkt_parser;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid, out_sop, out_ready;
    logic [31:0] out_data;
    logic        xfer_valid, xfer_dir, xfer_done = 1'b0;
    logic [31:0] xfer_pos, xfer_size;
    logic        dirty;
    logic [12:0] status_low;
    logic [255:0] env_out;

    always #2.5 clk = ~clk;

    cmdpkt_parser dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_ready(out_ready), .xfer_valid(xfer_valid),
        .xfer_dir(xfer_dir), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .xfer_done(xfer_done), .dirty(dirty), .status_low(status_low),
        .env_out(env_out)
    );

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    // backpressure generator, updated on the rising edge
    logic       bp_mode = 1'b0;
    logic [3:0] bp_cnt = '0;
    always @(posedge clk) bp_cnt <= bp_cnt + 4'd1;
    assign out_ready = !bp_mode || (bp_cnt % 3 != 0);

    // reference model state
    logic [31:0] env_m [8];
    logic [31:0] pk [$];
    logic [32:0] exp_q [$];
    bit          exp_dirty = 0, exp_xfer = 0, exp_dir = 0;
    logic [31:0] exp_pos, exp_size;

    function automatic int plen(input logic [7:0] op);
        if (op == 8'hA0 || op == 8'hC0) return 2;
        if (op == 8'h80) return 3;
        if (op == 8'h02) return 2;
        if (op inside {[8'h3C:8'h3F]}) return 11;
        if (op inside {[8'h2C:8'h2F], [8'h34:8'h37]}) return 8;
        if (op inside {[8'h38:8'h3B]}) return 7;
        if (op inside {[8'h24:8'h27]}) return 6;
        if (op inside {[8'h30:8'h33]}) return 5;
        if (op inside {[8'h28:8'h2B], [8'h58:8'h5F]}) return 4;
        if (op inside {[8'h20:8'h23], [8'h48:8'h57], [8'h64:8'h67]}) return 3;
        if (op inside {[8'h40:8'h47], [8'h60:8'h63], [8'h74:8'h77], [8'h7C:8'h7F]}) return 2;
        if (op inside {[8'h68:8'h6B], [8'h70:8'h73], [8'h78:8'h7B]}) return 1;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    task automatic model_accept(input logic [31:0] w);
        logic [7:0] op;
        pk.push_back(w);
        op = pk[0][31:24];
        if (pk.size() == 1 && (op & 8'hF8) == 8'hE0) env_m[op & 7] = w;   // R5
        if ((op & 8'hF4) == 8'h24 && pk.size() == 5) env_m[1][8:0] = w[8:0]; // R4
        if ((op & 8'hF4) == 8'h34 && pk.size() == 6) env_m[1][8:0] = w[8:0]; // R4
        if (pk.size() == plen(op) + 1) begin
            if (op == 8'hA0 || op == 8'hC0) begin
                exp_xfer = 1; exp_dir = (op == 8'hC0);
                exp_pos = pk[1]; exp_size = pk[2];
            end else begin
                foreach (pk[i]) exp_q.push_back({(i == 0), pk[i]});
            end
            exp_dirty = (op >= 8'h02 && op <= 8'hBF);
            pk.delete();
        end
    endtask

    task automatic send(input logic [31:0] w, input int gap);
        bit ok;
        repeat (gap) @(negedge clk);
        ok = 0;
        while (!ok) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = w;
            ok = in_ready;
            @(posedge clk);
        end
        #1;
        in_valid = 1'b0;
        model_accept(w);
    endtask

    task automatic send_pkt(input logic [7:0] op, input logic [31:0] seed, input int gap);
        send({op, seed[23:0]}, gap);
        for (int i = 1; i <= plen(op); i++) send(seed ^ (32'h0101_0101 * i), gap);
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 200) begin
            @(negedge clk); n++;
        end
        @(negedge clk);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            logic [255:0] envm;
            for (int k = 0; k < 8; k++) envm[k*32 +: 32] = env_m[k];
            chk("R5", env_out, envm, "env");
            chk("R6", 256'(status_low), 256'({env_m[6][1:0], env_m[1][10:0]}), "status");
            chk("R9", 256'(dirty), 256'(exp_dirty), "dirty");
            chk("R7", 256'(xfer_valid), 256'(exp_xfer), "xfer_valid");
            if (exp_xfer && xfer_valid) begin
                chk("R7", 256'(xfer_dir), 256'(exp_dir), "xfer_dir");
                chk("R7", 256'(xfer_pos), 256'(exp_pos), "xfer_pos");
                chk("R7", 256'(xfer_size), 256'(exp_size), "xfer_size");
            end
            exp_dirty = 0; exp_xfer = 0;
            if (out_valid) begin
                chk("R3", 256'(in_ready), 256'(0), "in_ready while sending");
                if (out_ready) begin
                    if (exp_q.size() == 0) chk("R2", 256'(out_data), 256'hX, "unexpected word");
                    else begin
                        chk("R2", 256'({out_sop, out_data}), 256'(exp_q[0]), "out word");
                        void'(exp_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) env_m[k] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", 256'(in_ready), 256'(1), "in_ready");
        chk("R10", 256'(out_valid), 256'(0), "out_valid");
        chk("R10", 256'(status_low), 256'(0), "status");
        chk("R10", env_out, 256'(0), "env");
        started = 1;

        // R5, R6: settings headers
        send(32'hE1AB_C7FF, 0);
        send(32'hE600_0003, 0);
        send(32'hE512_3456, 1);
        drain();
        // R1: assorted lengths, back to back and with gaps
        send_pkt(8'h02, 32'h1111_0000, 0);
        send_pkt(8'h6C, 32'h2222_0000, 0);
        send_pkt(8'h48, 32'h3333_0000, 2);
        send_pkt(8'h58, 32'h4444_0000, 0);
        send_pkt(8'h3C, 32'h5555_0000, 0);
        send_pkt(8'h80, 32'h6666_0000, 1);
        send_pkt(8'h77, 32'h7777_0000, 0);
        send_pkt(8'h00, 32'h8888_0000, 0);
        send_pkt(8'hF3, 32'h9999_0000, 0);
        drain();
        // R4: texture page capture, flat and shaded
        send_pkt(8'h26, 32'hA5A5_5A5A, 0);
        drain();
        send_pkt(8'h35, 32'h0F0F_01C3, 1);
        drain();
        // R2: partial packet held during a long input gap
        send(32'h2800_0000, 0);
        send(32'h0000_0011, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R2", 256'(out_valid), 256'(0), "partial forwarded");
        end
        send(32'h0000_0022, 0);
        send(32'h0000_0033, 0);
        send(32'h0000_0044, 0);
        drain();
        // R3: backpressure on output
        bp_mode = 1'b1;
        send_pkt(8'h2E, 32'hBEEF_0000, 0);
        send_pkt(8'h74, 32'hCAFE_0000, 0);
        drain();
        bp_mode = 1'b0;
        // R7, R8, R9: write transfer: dirty and transfer request together
        send_pkt(8'hA0, 32'h0010_0020, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8", 256'(in_ready), 256'(0), "in_ready during write");
        end
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R8", 256'(in_ready), 256'(1), "in_ready after done");
        // R7: read transfer, no stall, no dirty
        send_pkt(8'hC0, 32'h0030_0040, 0);
        send_pkt(8'h02, 32'h0050_0060, 0);
        drain();
        // second write with gaps
        send_pkt(8'hA0, 32'h0070_0080, 2);
        repeat (2) @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        send(32'hE100_0000, 0);
        drain();
        chk("R2", 256'(exp_q.size()), 256'(0), "words left");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule